// File: doc/BRIEF.md
# Double-Buffered USB IN Endpoint Buffer

This block is the transmit buffer of one USB IN endpoint. It has two payload banks. Firmware fills a free bank one byte at a time, then commits it with a byte count. A commit hands the bank to the USB side. While the USB engine sends one bank, firmware can load the other, so a new packet is always waiting and the endpoint can keep full bandwidth.

On the USB side the rest of the device core is reduced to single-cycle strobes: an IN token, a byte-read strobe, a host ACK and a no-handshake timeout. On a token the block either streams the next bank in turn, byte by byte, or answers with a NAK pulse. An ACK releases the bank, moves to the other bank and raises a completion flag that drives an interrupt. Only firmware can clear that flag. A timeout keeps the bank locked so that the next token sends the same data again.

Top module: `pingpong_in_ep`

## Requirements
- R1: After reset, both ready bits, both lock bits, the completion flag, the interrupt, the error bit, `usb_nak` and `usb_sending` are 0, and `fw_next_bank` is 0.
- R2: A commit to a free bank sets that bank's bit in `fw_ready` and in `fw_lock`, and stores the byte count. A count above MAX_PKT (64) is stored as MAX_PKT.
- R3: A token that arrives while the sequencer is idle, and while the bank named by `fw_next_bank` is locked, starts a send in the following cycle. That bank's ready bit clears and its lock bit stays set. Bytes come out on `usb_data` from address 0 upward, one per `usb_rd`, with `usb_avail` high, exactly as many as the stored count. Then `usb_eop` is high for one cycle with `usb_avail` low. A count of 0 gives `usb_eop` at once.
- R4: A token that arrives while idle, with the next bank not locked, gives `usb_nak` high for exactly one cycle after the token and starts no send.
- R5: Banks are sent strictly in the order 0, 1, 0, …. `fw_next_bank` toggles only on an ACK. A ready bank 1 does not stop a NAK while bank 0 is the next bank.
- R6: An ACK that arrives after `usb_eop` clears the sent bank's lock bit, sets `fw_tx_comp` and `fw_irq`, and toggles `fw_next_bank`.
- R7: `fw_tx_comp` clears only on `fw_clr_comp`. A clear that arrives in the same cycle as an ACK leaves the flag set.
- R8: A timeout that arrives after `usb_eop` leaves the bank locked, its data unchanged and `fw_tx_comp` unchanged. The next token sends the same bytes again.
- R9: A byte write or a commit aimed at a locked bank is dropped and sets `fw_err`. `fw_err` stays set until `fw_clr_err` and is not cleared by a clear that arrives in the same cycle as a new error.
- R10: A firmware write to the free bank takes effect even in a cycle where the USB side reads a byte from the other bank, and it does not disturb that read.
- R11: Tokens that arrive while a send is in progress, or while a handshake is awaited, are ignored: they cause no NAK and no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_wr_en | input | 1 | Firmware byte write strobe |
| fw_wr_bank | input | 1 | Bank the byte write targets |
| fw_wr_addr | input | 6 | Byte address within the bank |
| fw_wr_data | input | 8 | Byte to store |
| fw_commit | input | 1 | Mark a bank as loaded and ready |
| fw_commit_bank | input | 1 | Bank being committed |
| fw_commit_len | input | 7 | Byte count of the committed packet |
| fw_clr_comp | input | 1 | Clear the completion flag |
| fw_clr_err | input | 1 | Clear the sticky error bit |
| fw_ready | output | 2 | Per-bank ready bits (committed, not yet taken) |
| fw_lock | output | 2 | Per-bank lock bits (owned by the USB side) |
| fw_tx_comp | output | 1 | Transmit completion flag |
| fw_irq | output | 1 | Interrupt request, high while the completion flag is set |
| fw_err | output | 1 | Sticky bit for an access to a locked bank |
| fw_next_bank | output | 1 | Bank that the next send will use |
| usb_in_tok | input | 1 | IN token strobe |
| usb_rd | input | 1 | Byte consumed strobe |
| usb_ack | input | 1 | Host ACK strobe |
| usb_timeout | input | 1 | No-handshake timeout strobe |
| usb_nak | output | 1 | NAK response pulse |
| usb_sending | output | 1 | Packet data phase in progress |
| usb_data | output | 8 | Current payload byte |
| usb_avail | output | 1 | `usb_data` holds a valid byte |
| usb_eop | output | 1 | All bytes of the packet have been consumed |

## Verification
The hardest situation to reach is a retry, where the bank is resent after a timeout while firmware pokes at the locked bank and the completion flag is cleared in the same cycle as the next ACK. Under random stimulus the completion handshake and the firmware strobes seldom line up. Directed steps therefore drive the timeout, the blocked write and the combined ACK-plus-clear on purpose, then read the resent bytes back. A random phase follows. It mixes bank loads, lengths above the limit, tokens on empty or out-of-order banks, and byte writes to the other bank during every read cycle. A bench model of ownership and bank contents predicts each result.

// File: rtl/pingpong_in_pkg.sv
package pingpong_in_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_t;

  // Stored packet length: requested count saturated to the bank size.
  function automatic int unsigned clamp_len(int unsigned req, int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

  // A bank belongs to the USB side while committed or awaiting its handshake.
  function automatic logic [1:0] lock_bits(logic [1:0] rdy, logic [1:0] infl);
    return rdy | infl;
  endfunction

endpackage

// File: rtl/pingpong_bank_ram.sv
module pingpong_bank_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic                     wbank,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     rbank,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  localparam int NBANK = 2;

  logic [DW-1:0] rd_b [NBANK];

  // Separate storage per bank: a write to one bank and a read from the other
  // in the same cycle use disjoint arrays.
  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (we && (wbank == 1'(b))) mem[waddr] <= wdata;
      end
      assign rd_b[b] = mem[raddr];
    end
  endgenerate

  assign rdata = rd_b[rbank];
endmodule

// File: rtl/pingpong_flags.sv
module pingpong_flags
  import pingpong_in_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_ok,
  input  logic               commit_bank,
  input  logic [CW-1:0]      commit_len,
  input  logic               take_evt,
  input  logic               ack_evt,
  input  logic               cur_bank,
  input  logic               bad_access,
  input  logic               clr_comp,
  input  logic               clr_err,
  output logic [1:0]         ready,
  output logic [1:0]         infl,
  output logic [1:0][CW-1:0] len_q,
  output logic               comp,
  output logic               err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= '0;
      infl  <= '0;
      len_q <= '0;
      comp  <= 1'b0;
      err   <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (commit_ok && (commit_bank == 1'(b))) begin
          ready[b] <= 1'b1;
          len_q[b] <= commit_len;
        end else if (take_evt && (cur_bank == 1'(b))) begin
          ready[b] <= 1'b0;
        end
        if (take_evt && (cur_bank == 1'(b)))     infl[b] <= 1'b1;
        else if (ack_evt && (cur_bank == 1'(b))) infl[b] <= 1'b0;
      end
      // Hardware set has priority over the firmware clear.
      if (ack_evt)       comp <= 1'b1;
      else if (clr_comp) comp <= 1'b0;
      if (bad_access)    err  <= 1'b1;
      else if (clr_err)  err  <= 1'b0;
    end
  end
endmodule

// File: rtl/pingpong_tx_seq.sv
module pingpong_tx_seq
  import pingpong_in_pkg::*;
#(
  parameter int CW = 7,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok,
  input  logic          rd,
  input  logic          ack,
  input  logic          tmo,
  input  logic          has_data,
  input  logic [CW-1:0] cur_len,
  output logic          nb,
  output logic [AW-1:0] rd_addr,
  output logic          sending,
  output logic          nak,
  output logic          avail,
  output logic          eop,
  output logic          take_evt,
  output logic          ack_evt
);
  tx_state_t     state;
  logic [CW-1:0] cnt;

  assign take_evt = (state == TX_IDLE) && tok && has_data;
  assign ack_evt  = (state == TX_WAIT) && ack;
  assign sending  = (state == TX_SEND);
  assign eop      = sending && (cnt == cur_len);
  assign avail    = sending && (cnt < cur_len);
  assign rd_addr  = cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      nb    <= 1'b0;
      nak   <= 1'b0;
    end else begin
      nak <= 1'b0;
      unique case (state)
        TX_IDLE: begin
          if (tok) begin
            if (has_data) begin
              state <= TX_SEND;
              cnt   <= '0;
            end else begin
              nak <= 1'b1;
            end
          end
        end
        TX_SEND: begin
          if (cnt == cur_len) state <= TX_WAIT;
          else if (rd)        cnt   <= cnt + 1'b1;
        end
        TX_WAIT: begin
          if (ack) begin
            state <= TX_IDLE;
            nb    <= ~nb;
          end else if (tmo) begin
            state <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_in_ep.sv
module pingpong_in_ep
  import pingpong_in_pkg::*;
#(
  parameter int MAX_PKT = 64,
  parameter int DW      = 8,
  localparam int AW     = $clog2(MAX_PKT),
  localparam int CW     = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fw_wr_en,
  input  logic          fw_wr_bank,
  input  logic [AW-1:0] fw_wr_addr,
  input  logic [DW-1:0] fw_wr_data,
  input  logic          fw_commit,
  input  logic          fw_commit_bank,
  input  logic [CW-1:0] fw_commit_len,
  input  logic          fw_clr_comp,
  input  logic          fw_clr_err,
  output logic [1:0]    fw_ready,
  output logic [1:0]    fw_lock,
  output logic          fw_tx_comp,
  output logic          fw_irq,
  output logic          fw_err,
  output logic          fw_next_bank,
  input  logic          usb_in_tok,
  input  logic          usb_rd,
  input  logic          usb_ack,
  input  logic          usb_timeout,
  output logic          usb_nak,
  output logic          usb_sending,
  output logic [DW-1:0] usb_data,
  output logic          usb_avail,
  output logic          usb_eop
);
  logic [1:0]         infl;
  logic [1:0][CW-1:0] len_q;
  logic [AW-1:0]      rd_addr;
  logic               take_evt, ack_evt;
  logic               wr_blocked, cm_blocked, wr_ok, cm_ok;
  logic [CW-1:0]      cm_len;

  assign fw_lock    = lock_bits(fw_ready, infl);
  assign wr_blocked = fw_wr_en  && fw_lock[fw_wr_bank];
  assign cm_blocked = fw_commit && fw_lock[fw_commit_bank];
  assign wr_ok      = fw_wr_en  && !fw_lock[fw_wr_bank];
  assign cm_ok      = fw_commit && !fw_lock[fw_commit_bank];
  assign cm_len     = CW'(clamp_len(int'(fw_commit_len), MAX_PKT));
  assign fw_irq     = fw_tx_comp;

  pingpong_bank_ram #(.DEPTH(MAX_PKT), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .wbank (fw_wr_bank),
    .waddr (fw_wr_addr),
    .wdata (fw_wr_data),
    .rbank (fw_next_bank),
    .raddr (rd_addr),
    .rdata (usb_data)
  );

  pingpong_flags #(.CW(CW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_ok   (cm_ok),
    .commit_bank (fw_commit_bank),
    .commit_len  (cm_len),
    .take_evt    (take_evt),
    .ack_evt     (ack_evt),
    .cur_bank    (fw_next_bank),
    .bad_access  (wr_blocked || cm_blocked),
    .clr_comp    (fw_clr_comp),
    .clr_err     (fw_clr_err),
    .ready       (fw_ready),
    .infl        (infl),
    .len_q       (len_q),
    .comp        (fw_tx_comp),
    .err         (fw_err)
  );

  pingpong_tx_seq #(.CW(CW), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok      (usb_in_tok),
    .rd       (usb_rd),
    .ack      (usb_ack),
    .tmo      (usb_timeout),
    .has_data (fw_lock[fw_next_bank]),
    .cur_len  (len_q[fw_next_bank]),
    .nb       (fw_next_bank),
    .rd_addr  (rd_addr),
    .sending  (usb_sending),
    .nak      (usb_nak),
    .avail    (usb_avail),
    .eop      (usb_eop),
    .take_evt (take_evt),
    .ack_evt  (ack_evt)
  );
endmodule

// File: rtl/pingpong_in_ep_chk.sv
module pingpong_in_ep_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       usb_in_tok,
  input logic       usb_nak,
  input logic       usb_sending,
  input logic       usb_avail,
  input logic       fw_wr_en,
  input logic       fw_wr_bank,
  input logic [1:0] fw_lock,
  input logic       fw_err,
  input logic       fw_clr_err,
  input logic       fw_tx_comp,
  input logic       fw_clr_comp,
  input logic       fw_next_bank,
  input logic       take_evt,
  input logic       ack_evt
);
  a_r4_nak_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    usb_nak |=> !usb_nak);
  a_r4_nak_from_token: assert property (@(posedge clk) disable iff (!rst_n)
    usb_nak |-> $past(usb_in_tok));
  a_r11_no_nak_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    usb_sending |=> !usb_nak);
  a_r3_take_starts_send: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> usb_sending);
  a_r3_avail_in_send: assert property (@(posedge clk) disable iff (!rst_n)
    usb_avail |-> usb_sending);
  a_r6_comp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> fw_tx_comp);
  a_r7_comp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_tx_comp && !fw_clr_comp) |=> fw_tx_comp);
  a_r5_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_evt |=> $stable(fw_next_bank));
  a_r5_bank_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> (fw_next_bank != $past(fw_next_bank)));
  a_r9_err_on_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_wr_en && fw_lock[fw_wr_bank]) |=> fw_err);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_err && !fw_clr_err) |=> fw_err);
endmodule

bind pingpong_in_ep pingpong_in_ep_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .usb_in_tok   (usb_in_tok),
  .usb_nak      (usb_nak),
  .usb_sending  (usb_sending),
  .usb_avail    (usb_avail),
  .fw_wr_en     (fw_wr_en),
  .fw_wr_bank   (fw_wr_bank),
  .fw_lock      (fw_lock),
  .fw_err       (fw_err),
  .fw_clr_err   (fw_clr_err),
  .fw_tx_comp   (fw_tx_comp),
  .fw_clr_comp  (fw_clr_comp),
  .fw_next_bank (fw_next_bank),
  .take_evt     (take_evt),
  .ack_evt      (ack_evt)
);

// File: tb/test_pingpong_in_ep.sv
module test_pingpong_in_ep;
  localparam int MAXP = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fw_wr_en = 0, fw_wr_bank = 0, fw_commit = 0, fw_commit_bank = 0;
  logic [5:0] fw_wr_addr = '0;
  logic [7:0] fw_wr_data = '0;
  logic [6:0] fw_commit_len = '0;
  logic       fw_clr_comp = 0, fw_clr_err = 0;
  logic [1:0] fw_ready, fw_lock;
  logic       fw_tx_comp, fw_irq, fw_err, fw_next_bank;
  logic       usb_in_tok = 0, usb_rd = 0, usb_ack = 0, usb_timeout = 0;
  logic       usb_nak, usb_sending, usb_avail, usb_eop;
  logic [7:0] usb_data;

  int errors = 0;
  int checks = 0;

  // bench model
  logic [7:0] m_mem [2][MAXP];
  int         m_len [2];
  logic [1:0] m_ready = '0, m_infl = '0;
  logic       m_nb = 1'b0, m_comp = 1'b0, m_err = 1'b0;

  always #5 clk = ~clk;

  pingpong_in_ep i_pingpong_in_ep (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_len(int req);
    return (req > MAXP) ? MAXP : req;
  endfunction

  function automatic bit m_locked(logic b);
    return m_ready[b] || m_infl[b];
  endfunction

  task automatic check_flags(string req);
    chk(fw_ready == m_ready, req, "ready", fw_ready, m_ready);
    chk(fw_lock == (m_ready | m_infl), req, "lock", fw_lock, m_ready | m_infl);
    chk(fw_tx_comp == m_comp, req, "tx_comp", fw_tx_comp, m_comp);
    chk(fw_irq == m_comp, req, "irq", fw_irq, m_comp);
    chk(fw_err == m_err, req, "err", fw_err, m_err);
    chk(fw_next_bank == m_nb, req, "next_bank", fw_next_bank, m_nb);
  endtask

  // drive a byte write for the current cycle and update the model
  task automatic drive_wr(logic b, int a, logic [7:0] d);
    fw_wr_en = 1; fw_wr_bank = b; fw_wr_addr = 6'(a); fw_wr_data = d;
    if (m_locked(b)) m_err = 1'b1;
    else m_mem[b][a] = d;
  endtask

  task automatic fw_write(logic b, int a, logic [7:0] d);
    drive_wr(b, a, d);
    tick();
    fw_wr_en = 0;
  endtask

  task automatic fw_cm(logic b, int len);
    fw_commit = 1; fw_commit_bank = b; fw_commit_len = 7'(len);
    if (m_locked(b)) m_err = 1'b1;
    else begin m_ready[b] = 1'b1; m_len[b] = exp_len(len); end
    tick();
    fw_commit = 0;
  endtask

  task automatic load_bank(logic b, int len);
    for (int i = 0; i < exp_len(len); i++) fw_write(b, i, 8'($urandom));
    fw_cm(b, len);
  endtask

  // token; returns whether a send started
  task automatic token(string req, output bit started);
    bit has;
    has = m_locked(m_nb);
    usb_in_tok = 1;
    tick();
    usb_in_tok = 0;
    if (has) begin
      m_ready[m_nb] = 1'b0; m_infl[m_nb] = 1'b1;
      chk(usb_sending == 1 && usb_nak == 0, req, "send start", usb_sending, 1);
    end else begin
      chk(usb_nak == 1 && usb_sending == 0, req, "nak", usb_nak, 1);
      tick();
      chk(usb_nak == 0, req, "nak one cycle", usb_nak, 0);
    end
    started = has;
  endtask

  // consume the packet; optional concurrent writes to the other bank
  // and a stray token in the first read cycle
  task automatic drain(string req, bit cw, bit spur);
    logic b;
    b = m_nb;
    for (int i = 0; i < m_len[b]; i++) begin
      chk(usb_avail == 1, req, "avail", usb_avail, 1);
      chk(usb_data == m_mem[b][i], req, "byte", usb_data, m_mem[b][i]);
      usb_rd = 1;
      if (cw) drive_wr(~b, i, 8'($urandom));
      if (spur && i == 0) usb_in_tok = 1;
      tick();
      usb_rd = 0; fw_wr_en = 0; usb_in_tok = 0;
      if (spur && i == 0)
        chk(usb_nak == 0 && usb_sending == 1, "R11", "stray token", usb_nak, 0);
    end
    chk(usb_eop == 1 && usb_avail == 0, req, "eop", usb_eop, 1);
    tick();
    chk(usb_sending == 0, req, "send phase over", usb_sending, 0);
  endtask

  task automatic finish_pkt(bit ack, bit clr);
    usb_ack = ack; usb_timeout = !ack; fw_clr_comp = clr;
    if (ack) begin m_infl[m_nb] = 1'b0; m_nb = ~m_nb; m_comp = 1'b1; end
    else if (clr) m_comp = 1'b0;
    tick();
    usb_ack = 0; usb_timeout = 0; fw_clr_comp = 0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    bit st;
    logic [7:0] keep [5];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_flags("R1");
    chk(usb_sending == 0 && usb_nak == 0, "R1", "usb idle", usb_sending, 0);

    // R4 empty endpoint
    token("R4", st);
    // R5 bank 1 ready but bank 0 is next
    load_bank(1'b1, 5);
    check_flags("R2");
    token("R5", st);
    chk(st == 0, "R5", "no out-of-order send", st, 0);
    // R3 zero-length packet on bank 0
    fw_cm(1'b0, 0);
    token("R3", st);
    chk(usb_eop == 1 && usb_avail == 0, "R3", "zlp eop", usb_eop, 1);
    tick();
    finish_pkt(1, 0);
    check_flags("R6");
    // bank 1: concurrent writes into bank 0 + stray token, then timeout
    for (int i = 0; i < 5; i++) keep[i] = m_mem[1][i];
    token("R3", st);
    drain("R3", 1, 1);
    finish_pkt(0, 0);
    check_flags("R8");
    finish_pkt(0, 1);
    m_comp = 0;
    check_flags("R7");
    // R9 write and commit to locked bank 1
    fw_write(1'b1, 0, 8'hA5);
    fw_cm(1'b1, 3);
    check_flags("R9");
    // R8 resend of unchanged data
    token("R8", st);
    for (int i = 0; i < 5; i++)
      chk(m_mem[1][i] == keep[i], "R8", "model data kept", m_mem[1][i], keep[i]);
    drain("R8", 0, 0);
    // R7 clear and ACK in the same cycle
    finish_pkt(1, 1);
    check_flags("R7");
    // R9 clear of error
    fw_clr_err = 1; m_err = 0; tick(); fw_clr_err = 0;
    check_flags("R9");
    // R10 bank 0 contents written during the bank 1 reads
    fw_cm(1'b0, 5);
    token("R10", st);
    drain("R10", 0, 0);
    finish_pkt(1, 0);
    check_flags("R10");
    // R2 over-long count saturates
    load_bank(1'b1, 70);
    token("R2", st);
    drain("R2", 1, 0);
    finish_pkt(1, 0);
    check_flags("R2");

    // random phase
    for (int it = 0; it < 300; it++) begin
      int act;
      act = $urandom % 7;
      case (act)
        0: load_bank(1'($urandom), $urandom % 70);
        1: fw_write(1'($urandom), $urandom % MAXP, 8'($urandom));
        2, 3, 4: begin
          token("R3", st);
          if (st) begin
            drain("R3", 1, 1'($urandom));
            finish_pkt(($urandom % 4) != 0, 1'($urandom));
          end
        end
        5: begin fw_clr_comp = 1; m_comp = 0; tick(); fw_clr_comp = 0; end
        default: begin fw_clr_err = 1; m_err = 0; tick(); fw_clr_err = 0; end
      endcase
      check_flags("R5");
    end
    report();
  end
endmodule